// File: doc/BRIEF.md
# Paired-lane delay-commutator shuffler

The block sits between two stages of a parallel feedforward FFT. It reorders the data that arrive on P parallel lanes. The lanes are taken two at a time, so lane 2j is the upper lane and lane 2j+1 is the lower lane of pair j. Each pair exchanges blocks of DEPTH samples between its two lanes.

Inside a pair, the data take this path:
- The upper input passes through a delay of DEPTH samples.
- A pair of 2:1 multiplexers then either passes the two streams straight or crosses them.
- The resulting lower stream passes through a second delay of DEPTH samples.

Every pair uses the same select. All the upper-side delays share one circular memory, DEPTH deep and DATA_W·P/2 wide, and all the lower-side delays share a second one. Both memories use a single address counter, which advances only on valid samples.

Time inside the block is counted in accepted samples, not in clock cycles. A cycle with `in_valid_i` low changes nothing. The memory style is a parameter:
- Distributed: a register array with an asynchronous read.
- Block: a synchronous read that looks one address ahead.

Both styles give the same behaviour. With DEPTH = 0 the block reduces to wires.

Top module: `dc_shuffler`

## Requirements
- R1: After reset, and until DEPTH valid samples have been accepted, `out_valid_o` is low.
- R2: For DEPTH ≥ 1, `out_valid_o` is high exactly in the cycles where `in_valid_i` is high and the sample index t (0-based, counted over valid samples since reset) is at least DEPTH. The outputs are combinational on the current input.
- R3: Lane k occupies bits [k·DATA_W +: DATA_W] of the data buses. Pair j is formed by lane 2j (upper) and lane 2j+1 (lower).
- R4: In a valid cycle with t ≥ DEPTH and floor(t/DEPTH) odd, the upper output of each pair equals the current lower input.
- R5: In a valid cycle with floor(t/DEPTH) odd, the lower output equals the lower input of sample t−DEPTH.
- R6: In a valid cycle with floor(t/DEPTH) even and at least 2, the upper output equals the upper input of sample t−DEPTH.
- R7: In a valid cycle with floor(t/DEPTH) even and at least 2, the lower output equals the upper input of sample t−2·DEPTH.
- R8: A cycle with `in_valid_i` low drives `out_valid_o` low. It advances neither the address, nor the select, nor the stored data.
- R9: All pairs switch on the same sample index, and each pair carries only its own lanes.
- R10: With DEPTH = 0, `out_data_o` equals `in_data_i` and `out_valid_o` equals `in_valid_i`.
- R11: The block memory style gives results identical to the distributed style for every DEPTH ≥ 1, including DEPTH = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input sample valid |
| in_data_i | input | LANES·DATA_W | Input lanes, lane k at bits k·DATA_W |
| out_valid_o | output | 1 | Output sample valid |
| out_data_o | output | LANES·DATA_W | Output lanes, same layout as the input |

## Verification
The hardest case to reach is the block-memory style with DEPTH = 1. Its look-ahead read must forward the sample written in the same cycle. Any idle cycle in between hides that path, so the stimulus has to deliver back-to-back valid samples.

A second difficult case is an idle cycle that lands exactly on a block boundary, where the select toggles. The bench feeds the same stream to several instances: one with an odd depth, two with the block style, and one with depth zero. It runs through several phases:
- a continuous burst,
- alternating valid cycles,
- irregular gaps,
- gaps on a fixed period.

Together these phases land idle cycles on every address phase, including the wrap. On every clock, a queue of accepted samples predicts the output of each instance.

// File: rtl/dc_shuffler_pkg.sv
package dc_shuffler_pkg;
  typedef enum logic {
    MEM_DIST  = 1'b0,
    MEM_BLOCK = 1'b1
  } mem_kind_e;
endpackage

// File: rtl/dc_ctrl.sv
module dc_ctrl #(
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  output logic [AW-1:0] addr_o,
  output logic          sel_o,
  output logic          primed_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      sel_o    <= 1'b0;
      primed_o <= 1'b0;
    end else if (valid_i) begin
      if (addr_o == LAST) begin
        addr_o   <= '0;
        sel_o    <= ~sel_o;
        primed_o <= 1'b1;
      end else begin
        addr_o <= addr_o + 1'b1;
      end
    end
  end

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(addr_o) && $stable(sel_o)));
  // R4
  sel_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && addr_o == LAST) |=> (sel_o != $past(sel_o)));
  // R2
  primed_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_o |=> primed_o);
  // R1
  primed_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(primed_o) |-> $past(valid_i));
  // R2
  addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_o <= LAST);
endmodule

// File: rtl/dc_mem.sv
module dc_mem
  import dc_shuffler_pkg::*;
#(
  parameter int        WIDTH    = 32,
  parameter int        DEPTH    = 4,
  parameter mem_kind_e MEM_KIND = MEM_DIST,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  generate
    if (MEM_KIND == MEM_DIST) begin : g_dist
      assign rdata_o = mem_q[addr_i];
    end else begin : g_block
      // read one address ahead; forward the word written to that same address
      logic [AW-1:0]    addr_nxt;
      logic [WIDTH-1:0] rd_q;
      always_comb begin
        addr_nxt = addr_i;
        if (we_i) addr_nxt = (addr_i == LAST) ? '0 : addr_i + 1'b1;
      end
      always_ff @(posedge clk_i) begin
        rd_q <= (we_i && addr_nxt == addr_i) ? wdata_i : mem_q[addr_nxt];
      end
      assign rdata_o = rd_q;
    end
  endgenerate
endmodule

// File: rtl/dc_xbar.sv
module dc_xbar #(
  parameter int LANES  = 8,
  parameter int DATA_W = 16,
  localparam int HALF   = LANES / 2,
  localparam int SIDE_W = HALF * DATA_W
) (
  input  logic              sel_i,
  input  logic [SIDE_W-1:0] up_dly_i,
  input  logic [SIDE_W-1:0] lo_in_i,
  output logic [SIDE_W-1:0] up_mid_o,
  output logic [SIDE_W-1:0] lo_mid_o
);
  for (genvar j = 0; j < HALF; j++) begin : g_pair
    assign up_mid_o[j*DATA_W +: DATA_W] = sel_i ? lo_in_i[j*DATA_W +: DATA_W]
                                                : up_dly_i[j*DATA_W +: DATA_W];
    assign lo_mid_o[j*DATA_W +: DATA_W] = sel_i ? up_dly_i[j*DATA_W +: DATA_W]
                                                : lo_in_i[j*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/dc_shuffler.sv
module dc_shuffler
  import dc_shuffler_pkg::*;
#(
  parameter int        LANES    = 8,
  parameter int        DATA_W   = 16,
  parameter int        DEPTH    = 4,
  parameter mem_kind_e MEM_KIND = MEM_DIST
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  input  logic [LANES*DATA_W-1:0] in_data_i,
  output logic                    out_valid_o,
  output logic [LANES*DATA_W-1:0] out_data_o
);
  localparam int HALF   = LANES / 2;
  localparam int SIDE_W = HALF * DATA_W;
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  generate
    if (DEPTH == 0) begin : g_wire
      assign out_valid_o = in_valid_i;
      assign out_data_o  = in_data_i;
    end else begin : g_buf
      logic [AW-1:0]     addr;
      logic              sel, primed;
      logic [SIDE_W-1:0] up_in, lo_in, up_dly, up_mid, lo_mid, lo_dly;

      for (genvar j = 0; j < HALF; j++) begin : g_lane
        assign up_in[j*DATA_W +: DATA_W] = in_data_i[(2*j)*DATA_W +: DATA_W];
        assign lo_in[j*DATA_W +: DATA_W] = in_data_i[(2*j+1)*DATA_W +: DATA_W];
        assign out_data_o[(2*j)*DATA_W +: DATA_W]   = up_mid[j*DATA_W +: DATA_W];
        assign out_data_o[(2*j+1)*DATA_W +: DATA_W] = lo_dly[j*DATA_W +: DATA_W];
      end

      dc_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk_i, .rst_ni, .valid_i(in_valid_i),
        .addr_o(addr), .sel_o(sel), .primed_o(primed)
      );

      dc_mem #(.WIDTH(SIDE_W), .DEPTH(DEPTH), .MEM_KIND(MEM_KIND)) u_mem_up (
        .clk_i, .we_i(in_valid_i), .addr_i(addr), .wdata_i(up_in), .rdata_o(up_dly)
      );

      dc_xbar #(.LANES(LANES), .DATA_W(DATA_W)) u_xbar (
        .sel_i(sel), .up_dly_i(up_dly), .lo_in_i(lo_in),
        .up_mid_o(up_mid), .lo_mid_o(lo_mid)
      );

      dc_mem #(.WIDTH(SIDE_W), .DEPTH(DEPTH), .MEM_KIND(MEM_KIND)) u_mem_lo (
        .clk_i, .we_i(in_valid_i), .addr_i(addr), .wdata_i(lo_mid), .rdata_o(lo_dly)
      );

      assign out_valid_o = in_valid_i & primed;

      // R8
      idle_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |-> !out_valid_o);
    end
  endgenerate
endmodule

// File: tb/dc_shuffler_bench.sv
`timescale 1ns/1ps
module dc_shuffler_bench;
  import dc_shuffler_pkg::*;
  localparam int LN = 4;
  localparam int DW = 8;
  localparam int BW = LN * DW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0;
  logic [BW-1:0] in_data = '0;
  logic ov_a, ov_b, ov_c, ov_w;
  logic [BW-1:0] od_a, od_b, od_c, od_w;

  int tot = 0;
  int fails = 0;
  int t = -1;
  logic [BW-1:0] hist[$];

  always #2.5 clk = ~clk;

  dc_shuffler #(.LANES(LN), .DATA_W(DW), .DEPTH(3), .MEM_KIND(MEM_DIST)) u_dc_shuffler (
    .clk_i(clk), .rst_ni, .in_valid_i(in_valid), .in_data_i(in_data),
    .out_valid_o(ov_a), .out_data_o(od_a));
  dc_shuffler #(.LANES(LN), .DATA_W(DW), .DEPTH(1), .MEM_KIND(MEM_BLOCK)) u_blk1 (
    .clk_i(clk), .rst_ni, .in_valid_i(in_valid), .in_data_i(in_data),
    .out_valid_o(ov_b), .out_data_o(od_b));
  dc_shuffler #(.LANES(LN), .DATA_W(DW), .DEPTH(4), .MEM_KIND(MEM_BLOCK)) u_blk4 (
    .clk_i(clk), .rst_ni, .in_valid_i(in_valid), .in_data_i(in_data),
    .out_valid_o(ov_c), .out_data_o(od_c));
  dc_shuffler #(.LANES(LN), .DATA_W(DW), .DEPTH(0), .MEM_KIND(MEM_DIST)) u_wire (
    .clk_i(clk), .rst_ni, .in_valid_i(in_valid), .in_data_i(in_data),
    .out_valid_o(ov_w), .out_data_o(od_w));

  function automatic logic [BW-1:0] model(int idx, int d);
    logic [BW-1:0] r;
    int b;
    b = idx / d;
    r = '0;
    for (int j = 0; j < LN/2; j++) begin
      if (b % 2 == 1) begin
        r[(2*j)*DW +: DW]   = hist[idx][(2*j+1)*DW +: DW];
        r[(2*j+1)*DW +: DW] = hist[idx-d][(2*j+1)*DW +: DW];
      end else begin
        r[(2*j)*DW +: DW]   = hist[idx-d][(2*j)*DW +: DW];
        r[(2*j+1)*DW +: DW] = hist[idx-2*d][(2*j)*DW +: DW];
      end
    end
    return r;
  endfunction

  task automatic check_one(input int d, input logic ov, input logic [BW-1:0] od,
                           input string who);
    logic ev;
    logic [BW-1:0] ed;
    string req;
    ed = '0;
    if (!in_valid) begin
      ev = 1'b0; req = "R1 R8";
    end else if (d == 0) begin
      ev = 1'b1; ed = in_data; req = "R10";
    end else if (t < d) begin
      ev = 1'b0; req = "R1 R2";
    end else begin
      ev = 1'b1; ed = model(t, d);
      req = ((t / d) % 2 == 1) ? "R4 R5 R3" : "R6 R7 R9";
    end
    tot++;
    if (ov !== ev) begin
      fails++;
      $display("FAIL %s R2 valid t=%0d: actual %b expected %b", who, t, ov, ev);
    end
    if (ev) begin
      tot++;
      if (od !== ed) begin
        fails++;
        $display("FAIL %s %s data t=%0d: actual %h expected %h", who, req, t, od, ed);
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++; tot++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", tot - fails, tot);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    for (int c = 0; c < 340; c++) begin
      @(negedge clk);
      if (c < 3)        in_valid = 1'b0;
      else if (c < 60)  in_valid = 1'b1;
      else if (c < 160) in_valid = (c % 2 == 0);
      else if (c < 260) in_valid = (($urandom % 10) < 7);
      else              in_valid = (c % 5 != 0);
      in_data = $urandom;
      if (in_valid) begin
        hist.push_back(in_data);
        t = hist.size() - 1;
      end
      #1;
      check_one(3, ov_a, od_a, "dist3");
      check_one(1, ov_b, od_b, "R11 blk1");
      check_one(4, ov_c, od_c, "R11 blk4");
      check_one(0, ov_w, od_w, "wire");
    end
    $display("%0d/%0d checks passed", tot - fails, tot);
    $finish;
  end
endmodule